// File: doc/BRIEF.md
# Dual-Width Lane Buffer

The block is the data buffer between a register-mapped bus and a serial shift engine. It is built as four byte-wide storage lanes that share one row pointer. It holds a transmit buffer and a receive buffer of the same construction.

On the transmit side, software or a DMA engine stores data in one of two ways. A word store fills all four lanes of one row, and byte `k` of the word goes into lane `k`. A byte store fills one row that carries a single byte in lane 0. The shift engine drains bytes one at a time, in rising lane order, from the oldest row.

On the receive side, the shift engine streams bytes in. They pack into lanes 0 to 3 of the row under construction. A row becomes readable when its fourth byte arrives, or earlier when the engine marks the byte as the last of a transfer. Software can read a whole row through the word port, or read byte by byte through the byte port, which steps a lane pointer modulo 4.

Each side exposes a live status vector for polling and DMA pacing. Each side also has a sticky flag for misuse: a store into a full side, a read from an empty side, or a word read with no whole word ready. A misused access changes nothing else.

Top module: `dual_width_lane_fifo`

## Requirements
- R1: A transmit word store places bits [7:0] in lane 0 and bits [8k+7:8k] in lane k. The shift port (`tx_sbyte`, consumed by `tx_shift`) presents lanes in order 0, 1, 2, 3, then the next row.
- R2: Each side holds DEPTH rows (16 by default). Sixteen word stores fill the transmit side with 64 bytes. Sixteen byte stores also fill it, because each byte store takes one row, so the byte port holds 16 bytes.
- R3: A receive byte read returns the lane at the read lane pointer and then advances the pointer modulo 4. A row is released after its last valid byte is read, and reading resumes at lane 0 of the next row.
- R4: Streamed receive bytes pack into lanes 0 to 3. A row becomes visible after its fourth byte, or after a byte sent with `rx_last`=1; it then holds that many bytes. Before then it is not reported as available.
- R5: Status bit 5 (word available) is 1 only when the oldest row holds four bytes and the read lane pointer is 0. Status bit 4 (byte available) is 1 whenever at least one row is visible. A receive word read returns lane 0 in bits [7:0].
- R6: Status bit 0 is empty (no visible rows). Bit 1 is half-full (rows >= DEPTH/2). Bit 2 is full (rows == DEPTH). All three follow the live occupancy.
- R7: Status bit 3 is the trigger. On the transmit side it is 1 while free rows >= TX_TRIG (4). On the receive side it is 1 while used rows >= RX_TRIG (4).
- R8: The following accesses are ignored: a store while full (even if a read happens in the same cycle), a byte read or shift while empty, and a word read while bit 5 is 0. Each of them sets status bit 6 (illegal access).
- R9: Bit 6 stays set until a cycle with the side's clear input high. If a new illegal access happens in that same cycle, the bit stays set.
- R10: After reset each side is empty. The transmit status reads 7'h09 (empty, trigger) and the receive status reads 7'h01.
- R11: A store and a read accepted in the same cycle keep the row count unchanged and preserve byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_word | input | 1 | Transmit word store strobe |
| tx_wdata | input | 32 | Transmit word store data |
| tx_wr_byte | input | 1 | Transmit byte store strobe |
| tx_wbyte | input | 8 | Transmit byte store data |
| tx_shift | input | 1 | Shift engine takes the presented byte |
| tx_sbyte | output | 8 | Byte presented to the shift engine |
| tx_clr_illegal | input | 1 | Clears transmit illegal flag |
| tx_status | output | 7 | Transmit status: [6] illegal, [5] word, [4] byte, [3] trigger, [2] full, [1] half, [0] empty |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_sbyte | input | 8 | Received byte |
| rx_last | input | 1 | Received byte closes its row |
| rx_rd_word | input | 1 | Receive word read strobe |
| rx_rd_byte | input | 1 | Receive byte read strobe |
| rx_rword | output | 32 | Receive word read data |
| rx_rbyte | output | 8 | Receive byte read data |
| rx_clr_illegal | input | 1 | Clears receive illegal flag |
| rx_status | output | 7 | Receive status, same bit layout as tx_status |

## Verification
Every strobe is taken on the rising edge that sees it. The status vectors and the presented read or shift data are decoded from registers, so they change just after that same edge. The bench drives strobes one time unit after a rising edge. It checks status one time unit after the edge that consumed the strobe. A falling-edge monitor compares the presented data against a scoreboard queue while the read strobe is still high, so each byte is compared before the edge that removes it. The ignored-access cases are checked through the status vector and through the scoreboard's byte count.

// File: rtl/dwlf_pkg.sv
package dwlf_pkg;
  localparam int LANES    = 4;
  localparam int ST_W     = 7;
  localparam int ST_EMPTY = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_TRIG  = 3;
  localparam int ST_BYTE  = 4;
  localparam int ST_WORD  = 5;
  localparam int ST_ILL   = 6;

  // number of bytes up to and including a lane
  function automatic logic [2:0] lane_count(input logic [1:0] lane);
    return {1'b0, lane} + 3'd1;
  endfunction

  // select one byte lane of a row
  function automatic logic [7:0] pick_lane(input logic [31:0] row, input logic [1:0] lane);
    return row[{lane, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/dwlf_lane.sv
module dwlf_lane #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dwlf_core.sv
module dwlf_core import dwlf_pkg::*; #(
  parameter int DEPTH        = 16,
  parameter int TRIG_LVL     = 4,
  parameter bit TRIG_ON_FREE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_word,
  input  logic [31:0]     word_in,
  input  logic            push_byte,
  input  logic [7:0]      byte_in,
  input  logic            push_stream,
  input  logic [7:0]      stream_in,
  input  logic            stream_last,
  input  logic            pop_word,
  input  logic            pop_byte,
  input  logic            clr_illegal,
  output logic [31:0]     head_row,
  output logic [1:0]      rd_lane,
  output logic [ST_W-1:0] status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TRIG_CNT = CW'(TRIG_LVL);

  function automatic logic [AW-1:0] row_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [AW-1:0] wr_row, rd_row;
  logic [CW-1:0] used;
  logic [1:0]    wr_lane;
  logic [2:0]    row_len [DEPTH];
  logic          illegal_q;
  logic          is_full, is_empty, is_half, is_trig, word_ok;
  logic [2:0]    head_len, commit_len;
  logic          any_push;
  logic          ev_push_word, ev_push_byte, ev_push_stream, ev_commit;
  logic          ev_pop_word, ev_pop_byte, ev_retire, ev_bad;

  // occupancy and alignment
  assign is_full  = (used == FULL_CNT);
  assign is_empty = (used == '0);
  assign is_half  = (used >= HALF_CNT);
  assign head_len = row_len[rd_row];
  assign word_ok  = !is_empty && (head_len == 3'd4) && (rd_lane == 2'd0);

  // accepted events, word > byte > stream on the producer side
  assign any_push       = push_word | push_byte | push_stream;
  assign ev_push_word   = push_word & !is_full;
  assign ev_push_byte   = push_byte & !push_word & !is_full;
  assign ev_push_stream = push_stream & !push_word & !push_byte & !is_full;
  assign ev_commit      = ev_push_word | ev_push_byte |
                          (ev_push_stream & (stream_last | (wr_lane == 2'd3)));
  assign commit_len     = ev_push_word ? 3'd4 : (ev_push_byte ? 3'd1 : lane_count(wr_lane));
  assign ev_pop_word    = pop_word & word_ok;
  assign ev_pop_byte    = pop_byte & !pop_word & !is_empty;
  assign ev_retire      = ev_pop_word | (ev_pop_byte & (lane_count(rd_lane) == head_len));
  assign ev_bad         = (any_push & is_full) | (pop_word & !word_ok) |
                          (pop_byte & !pop_word & is_empty);

  generate
    if (TRIG_ON_FREE) begin : g_trig_free
      assign is_trig = (FULL_CNT - used) >= TRIG_CNT;
    end else begin : g_trig_used
      assign is_trig = used >= TRIG_CNT;
    end
  endgenerate

  // four byte lanes sharing the row pointers
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       we;
    logic [7:0] wd;
    assign we = ev_push_word | (ev_push_byte && (l == 0)) |
                (ev_push_stream && (wr_lane == 2'(l)));
    assign wd = ev_push_word ? word_in[8*l +: 8] : (ev_push_byte ? byte_in : stream_in);
    dwlf_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk   (clk),
      .we    (we),
      .waddr (wr_row),
      .wdata (wd),
      .raddr (rd_row),
      .rdata (head_row[8*l +: 8])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_row    <= '0;
      rd_row    <= '0;
      used      <= '0;
      wr_lane   <= '0;
      rd_lane   <= '0;
      illegal_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) row_len[i] <= 3'd0;
    end else begin
      if (ev_commit) begin
        row_len[wr_row] <= commit_len;
        wr_row          <= row_step(wr_row);
        wr_lane         <= 2'd0;
      end else if (ev_push_stream) begin
        wr_lane <= wr_lane + 2'd1;
      end
      if (ev_retire) begin
        rd_row  <= row_step(rd_row);
        rd_lane <= 2'd0;
      end else if (ev_pop_byte) begin
        rd_lane <= rd_lane + 2'd1;
      end
      if (ev_commit && !ev_retire)      used <= used + CW'(1);
      else if (!ev_commit && ev_retire) used <= used - CW'(1);
      illegal_q <= (illegal_q & !clr_illegal) | ev_bad;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = is_empty;
    status[ST_HALF]  = is_half;
    status[ST_FULL]  = is_full;
    status[ST_TRIG]  = is_trig;
    status[ST_BYTE]  = !is_empty;
    status[ST_WORD]  = word_ok;
    status[ST_ILL]   = illegal_q;
  end

  // R6: occupancy never passes the row count
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL_CNT);
  // R8: a store while full leaves the store pointer where it was
  a_r8_full_store_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_FULL] && any_push) |=> (wr_row == $past(wr_row)));
  // R8: a byte read from an empty side raises the flag
  a_r8_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_byte && status[ST_EMPTY]) |=> status[ST_ILL]);
  // R9: the flag holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_ILL] && !clr_illegal) |=> status[ST_ILL]);
  // R3: a byte read inside a row steps the lane pointer by one
  a_r3_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop_byte && !ev_retire) |=> (rd_lane == $past(rd_lane) + 2'd1));
  // R5: after a word read the pointer is aligned
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_word |=> (rd_lane == 2'd0));
  // R11: occupancy moves by at most one row per cycle
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({1'b0, used} <= {1'b0, $past(used)} + (CW+1)'(1)) &&
              ({1'b0, used} + (CW+1)'(1) >= {1'b0, $past(used)})));
endmodule

// File: rtl/dual_width_lane_fifo.sv
module dual_width_lane_fifo import dwlf_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int TX_TRIG = 4,
  parameter int RX_TRIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_wr_word,
  input  logic [31:0]     tx_wdata,
  input  logic            tx_wr_byte,
  input  logic [7:0]      tx_wbyte,
  input  logic            tx_shift,
  output logic [7:0]      tx_sbyte,
  input  logic            tx_clr_illegal,
  output logic [ST_W-1:0] tx_status,
  input  logic            rx_push,
  input  logic [7:0]      rx_sbyte,
  input  logic            rx_last,
  input  logic            rx_rd_word,
  input  logic            rx_rd_byte,
  output logic [31:0]     rx_rword,
  output logic [7:0]      rx_rbyte,
  input  logic            rx_clr_illegal,
  output logic [ST_W-1:0] rx_status
);
  logic [31:0] tx_head, rx_head;
  logic [1:0]  tx_lane, rx_lane;

  dwlf_core #(.DEPTH(DEPTH), .TRIG_LVL(TX_TRIG), .TRIG_ON_FREE(1'b1)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_word   (tx_wr_word),
    .word_in     (tx_wdata),
    .push_byte   (tx_wr_byte),
    .byte_in     (tx_wbyte),
    .push_stream (1'b0),
    .stream_in   (8'h00),
    .stream_last (1'b0),
    .pop_word    (1'b0),
    .pop_byte    (tx_shift),
    .clr_illegal (tx_clr_illegal),
    .head_row    (tx_head),
    .rd_lane     (tx_lane),
    .status      (tx_status)
  );

  dwlf_core #(.DEPTH(DEPTH), .TRIG_LVL(RX_TRIG), .TRIG_ON_FREE(1'b0)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_word   (1'b0),
    .word_in     (32'h0),
    .push_byte   (1'b0),
    .byte_in     (8'h00),
    .push_stream (rx_push),
    .stream_in   (rx_sbyte),
    .stream_last (rx_last),
    .pop_word    (rx_rd_word),
    .pop_byte    (rx_rd_byte),
    .clr_illegal (rx_clr_illegal),
    .head_row    (rx_head),
    .rd_lane     (rx_lane),
    .status      (rx_status)
  );

  assign tx_sbyte = pick_lane(tx_head, tx_lane);
  assign rx_rword = rx_head;
  assign rx_rbyte = pick_lane(rx_head, rx_lane);
endmodule

// File: tb/dual_width_lane_fifo_tb.sv
module dual_width_lane_fifo_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr_word = 0, tx_wr_byte = 0, tx_shift = 0, tx_clr_illegal = 0;
  logic [31:0] tx_wdata = '0;
  logic [7:0] tx_wbyte = '0, tx_sbyte;
  logic [6:0] tx_status, rx_status;
  logic rx_push = 0, rx_last = 0, rx_rd_word = 0, rx_rd_byte = 0, rx_clr_illegal = 0;
  logic [7:0] rx_sbyte = '0, rx_rbyte;
  logic [31:0] rx_rword;

  int total = 0;
  int bad = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #2 clk = ~clk;

  dual_width_lane_fifo u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor: compares presented data while the read strobe is held
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_shift && !tx_status[0]) begin
        if (tx_q.size() == 0) chk("R1 shift beyond scoreboard", 32'(tx_sbyte), 32'hx);
        else chk("R1 serial byte order", 32'(tx_sbyte), 32'(tx_q.pop_front()));
      end
      if (rx_rd_word && rx_status[5]) begin
        if (rx_q.size() < 4) chk("R5 word beyond scoreboard", rx_rword, 32'hx);
        else begin
          logic [31:0] ew;
          ew[7:0] = rx_q.pop_front(); ew[15:8] = rx_q.pop_front();
          ew[23:16] = rx_q.pop_front(); ew[31:24] = rx_q.pop_front();
          chk("R4/R5 packed word", rx_rword, ew);
        end
      end else if (rx_rd_byte && !rx_rd_word && rx_status[4]) begin
        if (rx_q.size() == 0) chk("R3 byte beyond scoreboard", 32'(rx_rbyte), 32'hx);
        else chk("R3 byte lane order", 32'(rx_rbyte), 32'(rx_q.pop_front()));
      end
    end
  end

  task automatic tx_word(input logic [31:0] w, input bit ok);
    @(posedge clk); #1;
    tx_wr_word = 1; tx_wdata = w;
    if (ok) for (int k = 0; k < 4; k++) tx_q.push_back(w[8*k +: 8]);
    @(posedge clk); #1;
    tx_wr_word = 0;
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit ok, input bit clr);
    @(posedge clk); #1;
    tx_wr_byte = 1; tx_wbyte = b; tx_clr_illegal = clr;
    if (ok) tx_q.push_back(b);
    @(posedge clk); #1;
    tx_wr_byte = 0; tx_clr_illegal = 0;
  endtask

  task automatic tx_pull(input int n);
    @(posedge clk); #1;
    tx_shift = 1;
    repeat (n) @(posedge clk);
    #1 tx_shift = 0;
  endtask

  task automatic tx_clear();
    @(posedge clk); #1 tx_clr_illegal = 1;
    @(posedge clk); #1 tx_clr_illegal = 0;
  endtask

  task automatic rx_feed(input logic [7:0] b, input bit last);
    @(posedge clk); #1;
    rx_push = 1; rx_sbyte = b; rx_last = last;
    rx_q.push_back(b);
    @(posedge clk); #1;
    rx_push = 0; rx_last = 0;
  endtask

  task automatic rx_word();
    @(posedge clk); #1 rx_rd_word = 1;
    @(posedge clk); #1 rx_rd_word = 0;
  endtask

  task automatic rx_bytes(input int n);
    @(posedge clk); #1;
    rx_rd_byte = 1;
    repeat (n) @(posedge clk);
    #1 rx_rd_byte = 0;
  endtask

  task automatic rx_clear();
    @(posedge clk); #1 rx_clr_illegal = 1;
    @(posedge clk); #1 rx_clr_illegal = 0;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R10 tx reset status", 32'(tx_status), 32'h09);
    chk("R10 rx reset status", 32'(rx_status), 32'h01);

    // transmit word stores, fill levels
    for (int i = 0; i < 8; i++) tx_word(32'h10203040 + 32'(i) * 32'h01010101, 1);
    chk("R6 tx half after 8 words", 32'(tx_status), 32'h3A);
    for (int i = 8; i < 13; i++) tx_word(32'h10203040 + 32'(i) * 32'h01010101, 1);
    chk("R7 tx trigger drops at 3 free rows", 32'(tx_status), 32'h32);
    for (int i = 13; i < 16; i++) tx_word(32'h10203040 + 32'(i) * 32'h01010101, 1);
    chk("R2 tx full after 16 words", 32'(tx_status), 32'h36);
    tx_word(32'hDEADBEEF, 0);
    chk("R8 tx store while full flagged", 32'(tx_status), 32'h76);
    tx_pull(64);
    chk("R8 tx ignored word absent, empty after 64 bytes", 32'(tx_status), 32'h49);
    chk("R1 tx scoreboard drained", 32'(tx_q.size()), 32'd0);
    tx_clear();
    chk("R9 tx clear", 32'(tx_status), 32'h09);

    // transmit byte stores: one row each
    for (int i = 0; i < 16; i++) tx_byte(8'hC0 + 8'(i), 1, 0);
    chk("R2 tx full after 16 bytes", 32'(tx_status), 32'h16);
    tx_byte(8'hEE, 0, 0);
    chk("R8 tx byte store while full", 32'(tx_status), 32'h56);
    tx_byte(8'hEF, 0, 1);
    chk("R9 clear with new illegal keeps flag", 32'(tx_status), 32'h56);
    tx_clear();
    chk("R9 tx clear after full", 32'(tx_status), 32'h16);
    tx_pull(16);
    chk("R2 tx empty after 16 byte rows", 32'(tx_status), 32'h09);
    tx_pull(1);
    chk("R8 tx shift while empty", 32'(tx_status), 32'h49);
    tx_clear();

    // simultaneous store and shift
    tx_byte(8'hA5, 1, 0);
    @(posedge clk); #1;
    tx_wr_word = 1; tx_wdata = 32'h44332211; tx_shift = 1;
    for (int k = 0; k < 4; k++) tx_q.push_back(tx_wdata[8*k +: 8]);
    @(posedge clk); #1;
    tx_wr_word = 0; tx_shift = 0;
    chk("R11 tx count kept on store+shift", 32'(tx_status), 32'h38);
    tx_pull(4);
    chk("R11 tx empty after word", 32'(tx_status), 32'h09);

    // receive packing and word reads
    for (int i = 0; i < 8; i++) rx_feed(8'h50 + 8'(i), 0);
    chk("R4 rx two rows packed", 32'(rx_status), 32'h30);
    rx_word();
    rx_word();
    chk("R5 rx empty after two words", 32'(rx_status), 32'h01);

    // short row closed by last marker
    rx_feed(8'h61, 0);
    rx_feed(8'h62, 0);
    chk("R4 partial row not visible", 32'(rx_status), 32'h01);
    rx_feed(8'h63, 1);
    chk("R5 three-byte row: byte only", 32'(rx_status), 32'h10);
    rx_word();
    chk("R8 word read without word flagged", 32'(rx_status), 32'h50);
    rx_clear();
    rx_bytes(3);
    chk("R3 short row released", 32'(rx_status), 32'h01);

    // byte reads across a full row
    for (int i = 0; i < 4; i++) rx_feed(8'h70 + 8'(i), 0);
    rx_bytes(1);
    chk("R5 word flag drops off alignment", 32'(rx_status), 32'h10);
    rx_bytes(3);
    chk("R3 lane pointer wraps, row released", 32'(rx_status), 32'h01);
    rx_bytes(1);
    chk("R8 rx byte read while empty", 32'(rx_status), 32'h41);
    rx_clear();

    // receive trigger and half
    for (int i = 0; i < 16; i++) rx_feed(8'h80 + 8'(i), 0);
    chk("R7 rx trigger at 4 rows", 32'(rx_status), 32'h38);
    for (int i = 16; i < 32; i++) rx_feed(8'h80 + 8'(i), 0);
    chk("R6 rx half at 8 rows", 32'(rx_status), 32'h3A);
    for (int i = 0; i < 8; i++) rx_word();
    chk("R5 rx drained by words", 32'(rx_status), 32'h01);
    chk("R4 rx scoreboard drained", 32'(rx_q.size()), 32'd0);

    finish_up();
  end
endmodule